// File: doc/BRIEF.md
# Bit-Level Two-Wire EEPROM Responder

This block stands in for a small serial EEPROM on a two-wire bus whose clock and data lines are toggled by software. Each time the host writes the two line levels, the block gets a one-cycle strobe carrying the new clock and data bits. It compares them with the levels it kept from the previous strobe to find start and stop conditions and clock rising edges. It returns the data level the device would leave on the line.

A transfer begins with a start condition. Eight command bits follow, then an acknowledge slot, then eight address bits. On the final address bit the byte at that address is fetched from a 256-entry read-only table, and a second acknowledge slot is armed. If a later transfer has the read flag set in its command, the fetched byte is shifted out most-significant bit first on the returned data level during that transfer's address bits. A repeated start is not needed between the command and the address.

Top module: `twb_eeprom_resp`

## Requirements
- R1: After reset the returned data level is 1, the bit counter is 0, no acknowledge is pending, and the command, address and data registers are 0.
- R2: A strobe that keeps the clock high while the data level falls is a start. It sets the bit counter to 1 and clears the command register, from any state.
- R3: While the bit counter is 0 and no acknowledge is pending, every strobe except a start leaves the protocol state unchanged, and the returned level follows the host's data bit.
- R4: A bit is taken only on a clock rising edge (clock 0 at the previous strobe, 1 now) whose data level equals the previous strobe's level. A rising edge on which the data level also changed takes no bit.
- R5: At counts 1 to 8, each taken bit is shifted into the command register most-significant bit first. The eighth bit brings the count to 9 and arms an acknowledge.
- R6: The first clock rising edge after an acknowledge is armed forces the returned level to 0 and clears the armed flag, whether or not the data level changed. No bit is taken on that edge.
- R7: At counts 9 to 16, each taken bit is shifted into the address register most-significant bit first. When command bit 0 (the read flag) is 1, the returned level on that edge is the most-significant bit of the data register, and the data register shifts left by one.
- R8: The bit that completes the address loads the data register with the table byte at the new 8-bit address, arms an acknowledge, and returns the count to 0.
- R9: The table holds 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01, 0x40, 0x00 at addresses 0 to 7, 0x14 at 0x1B, 0xD0 at 0x3F, 0xF4 at 0x7F, and 0x00 at every address from 0x80 to 0xFF.
- R10: A strobe that keeps the clock high while the data level rises is a stop. It takes no bit and leaves the count and the acknowledge flag unchanged.
- R11: The returned level is the host's data bit from the latest strobe, except where R6 or R7 overrides it, and it holds between strobes. That returned value is also the previous data level used by the next strobe's edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | One-cycle strobe: new line levels are valid |
| bus_scl | input | 1 | Clock line level written by the host |
| bus_sda | input | 1 | Data line level written by the host |
| dev_sda | output | 1 | Data line level returned by the device |

## Verification
The bench builds the block with its default address width of eight bits. That makes the whole 256-byte table reachable, including the all-zero upper half and the entries just below the 0x40 and 0x80 boundaries. A reference model in the bench predicts the returned level after every strobe. The stimulus covers idle noise, a skewed rising edge in mid-command, a stop and a restart in mid-frame, and back-to-back reads that chain each fetched address into the next transfer's read-out.

// File: rtl/twb_pkg.sv
package twb_pkg;

  localparam int unsigned BYTE_W = 8;

  // Classification of one host strobe against the previous line levels
  typedef enum logic [2:0] {
    LN_NONE,
    LN_START,
    LN_STOP,
    LN_RISE_SAME,
    LN_RISE_SKEW,
    LN_OTHER
  } line_ev_e;

  // Fixed power-up contents; only non-zero entries are listed
  function automatic logic [BYTE_W-1:0] seed_byte(input logic [7:0] a);
    logic [BYTE_W-1:0] v;
    case (a)
      8'h00: v = 8'h80;  8'h01: v = 8'h08;  8'h02: v = 8'h04;  8'h03: v = 8'h0D;
      8'h04: v = 8'h0A;  8'h05: v = 8'h01;  8'h06: v = 8'h40;
      8'h08: v = 8'h01;  8'h09: v = 8'h75;  8'h0A: v = 8'h54;
      8'h0C: v = 8'h82;  8'h0D: v = 8'h08;  8'h0F: v = 8'h01;
      8'h10: v = 8'h8F;  8'h11: v = 8'h04;  8'h12: v = 8'h02;  8'h13: v = 8'h01;
      8'h14: v = 8'h01;  8'h16: v = 8'h0E;
      8'h1B: v = 8'h14;  8'h1C: v = 8'h0F;  8'h1D: v = 8'h14;  8'h1E: v = 8'h2D;
      8'h1F: v = 8'h40;
      8'h20: v = 8'h15;  8'h21: v = 8'h08;  8'h22: v = 8'h15;  8'h23: v = 8'h08;
      8'h3E: v = 8'h12;  8'h3F: v = 8'hD0;
      8'h7E: v = 8'h64;  8'h7F: v = 8'hF4;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/twb_rst_sync.sv
module twb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/twb_line_watch.sv
module twb_line_watch
  import twb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stb,
  input  logic     scl_i,
  input  logic     sda_i,
  input  logic     sda_keep,
  output line_ev_e ev,
  output logic     line_sda
);

  logic scl_q, sda_q;
  logic scl_d, sda_d;

  // Classify the strobe against the kept levels
  always_comb begin
    if (!stb) begin
      ev = LN_NONE;
    end else if (scl_q && scl_i && (sda_q != sda_i)) begin
      ev = sda_i ? LN_STOP : LN_START;
    end else if (!scl_q && scl_i) begin
      ev = (sda_q == sda_i) ? LN_RISE_SAME : LN_RISE_SKEW;
    end else begin
      ev = LN_OTHER;
    end
  end

  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    if (stb) begin
      scl_d = scl_i;
      sda_d = sda_keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign line_sda = sda_q;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(sda_q) && $stable(scl_q)));

endmodule

// File: rtl/twb_seq.sv
module twb_seq
  import twb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_ev_e          ev,
  input  logic              sda_i,
  output logic              force_low,
  output logic              drive_msb,
  output logic              shift_en,
  output logic              load_en,
  output logic [ADDR_W-1:0] load_addr
);

  localparam int unsigned ACK_AT  = BYTE_W + 1;
  localparam int unsigned LOAD_AT = BYTE_W + ADDR_W + 1;
  localparam int unsigned CNT_W   = $clog2(LOAD_AT + 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ACK    = CNT_W'(ACK_AT);
  localparam logic [CNT_W-1:0] CNT_PREACK = CNT_W'(ACK_AT - 1);
  localparam logic [CNT_W-1:0] CNT_PRELD  = CNT_W'(LOAD_AT - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ack_q, ack_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic              idle;
  logic              rise;

  assign idle      = (cnt_q == '0) && !ack_q;
  assign rise      = (ev == LN_RISE_SAME) || (ev == LN_RISE_SKEW);
  assign load_addr = {adr_q[ADDR_W-2:0], sda_i};

  always_comb begin
    cnt_d     = cnt_q;
    ack_d     = ack_q;
    cmd_d     = cmd_q;
    adr_d     = adr_q;
    force_low = 1'b0;
    drive_msb = 1'b0;
    shift_en  = 1'b0;
    load_en   = 1'b0;
    if (ev == LN_START) begin
      cnt_d = CNT_ONE;
      cmd_d = '0;
    end else if (rise && !idle) begin
      if (ack_q) begin
        force_low = 1'b1;
        ack_d     = 1'b0;
      end else if (ev == LN_RISE_SAME) begin
        if (cnt_q < CNT_ACK) begin
          cmd_d = {cmd_q[BYTE_W-2:0], sda_i};
          cnt_d = cnt_q + CNT_ONE;
          if (cnt_q == CNT_PREACK) ack_d = 1'b1;
        end else begin
          drive_msb = cmd_q[0];
          adr_d     = load_addr;
          shift_en  = 1'b1;
          if (cnt_q == CNT_PRELD) begin
            load_en = 1'b1;
            ack_d   = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
      cmd_q <= '0;
      adr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ack_q <= ack_d;
      cmd_q <= cmd_d;
      adr_q <= adr_d;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == LN_START) |=> (cnt_q == CNT_ONE && cmd_q == '0));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ev != LN_START) |=> (cnt_q == '0 && !ack_q && $stable(cmd_q) && $stable(adr_q)));

  p_skew_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == LN_RISE_SKEW && !ack_q) |=> ($stable(cnt_q) && $stable(cmd_q) && $stable(adr_q)));

  p_ack_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == LN_RISE_SAME && !ack_q && cnt_q == CNT_PREACK) |=> (ack_q && cnt_q == CNT_ACK));

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && rise) |=> (!ack_q && $stable(cnt_q)));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == '0 && ack_q));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == LN_STOP) |=> ($stable(cnt_q) && $stable(ack_q)));

endmodule

// File: rtl/twb_data_path.sv
module twb_data_path
  import twb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              data_msb
);

  logic [BYTE_W-1:0] data_q, data_d;
  logic [BYTE_W-1:0] fetched;

  assign fetched = seed_byte(8'(load_addr));

  always_comb begin
    data_d = data_q;
    if (load_en)       data_d = fetched;
    else if (shift_en) data_d = {data_q[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_msb = data_q[BYTE_W-1];

  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (data_q == ($past(data_q) << 1)));

endmodule

// File: rtl/twb_eeprom_resp.sv
module twb_eeprom_resp
  import twb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_wr,
  input  logic bus_scl,
  input  logic bus_sda,
  output logic dev_sda
);

  logic              rst_int_n;
  line_ev_e          ev;
  logic              force_low, drive_msb, shift_en, load_en;
  logic [ADDR_W-1:0] load_addr;
  logic              data_msb;
  logic              sda_keep;

  twb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  // Returned level: forced acknowledge, then read data, else host bit
  always_comb begin
    if (force_low)      sda_keep = 1'b0;
    else if (drive_msb) sda_keep = data_msb;
    else                sda_keep = bus_sda;
  end

  twb_line_watch u_watch (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .stb     (bus_wr),
    .scl_i   (bus_scl),
    .sda_i   (bus_sda),
    .sda_keep(sda_keep),
    .ev      (ev),
    .line_sda(dev_sda)
  );

  twb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ev       (ev),
    .sda_i    (bus_sda),
    .force_low(force_low),
    .drive_msb(drive_msb),
    .shift_en (shift_en),
    .load_en  (load_en),
    .load_addr(load_addr)
  );

  twb_data_path #(.ADDR_W(ADDR_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (shift_en),
    .load_en  (load_en),
    .load_addr(load_addr),
    .data_msb (data_msb)
  );

  p_low_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    force_low |=> !dev_sda);

endmodule

// File: tb/twb_eeprom_resp_bench.sv
`timescale 1ns/1ps
module twb_eeprom_resp_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_scl = 1'b1;
  logic bus_sda = 1'b1;
  logic dev_sda;

  always #2 clk = ~clk;

  twb_eeprom_resp u_twb_eeprom_resp (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_scl(bus_scl), .bus_sda(bus_sda), .dev_sda(dev_sda)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // scoreboard queues
  bit    exp_v[$];
  string exp_tag[$];
  logic  stb_seen = 1'b0;

  // reference model state
  bit       m_scl, m_sda, m_ack;
  int       m_tick;
  bit [7:0] m_cmd, m_adr, m_data;

  // R9 table as required
  function automatic bit [7:0] tbl(input bit [7:0] a);
    case (a)
      8'h00: return 8'h80; 8'h01: return 8'h08; 8'h02: return 8'h04; 8'h03: return 8'h0D;
      8'h04: return 8'h0A; 8'h05: return 8'h01; 8'h06: return 8'h40;
      8'h08: return 8'h01; 8'h09: return 8'h75; 8'h0A: return 8'h54;
      8'h0C: return 8'h82; 8'h0D: return 8'h08; 8'h0F: return 8'h01;
      8'h10: return 8'h8F; 8'h11: return 8'h04; 8'h12: return 8'h02; 8'h13: return 8'h01;
      8'h14: return 8'h01; 8'h16: return 8'h0E;
      8'h1B: return 8'h14; 8'h1C: return 8'h0F; 8'h1D: return 8'h14; 8'h1E: return 8'h2D;
      8'h1F: return 8'h40;
      8'h20: return 8'h15; 8'h21: return 8'h08; 8'h22: return 8'h15; 8'h23: return 8'h08;
      8'h3E: return 8'h12; 8'h3F: return 8'hD0;
      8'h7E: return 8'h64; 8'h7F: return 8'hF4;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_scl = 1; m_sda = 1; m_ack = 0; m_tick = 0;
    m_cmd = 0; m_adr = 0; m_data = 0;
  endtask

  task automatic model_step(input bit scl, input bit sda, output bit ret);
    bit s;
    s = sda;
    if (m_scl && scl && (m_sda != sda)) begin
      if (!sda) begin m_tick = 1; m_cmd = 0; end        // R2 start, R10 stop
    end else if (m_tick == 0 && !m_ack) begin
      // R3 idle
    end else if (!m_scl && scl) begin
      if (m_ack) begin s = 0; m_ack = 0; end            // R6
      else if (m_sda == sda) begin                      // R4
        if (m_tick < 9) begin                           // R5
          m_cmd = {m_cmd[6:0], sda};
          m_tick++;
          if (m_tick == 9) m_ack = 1;
        end else begin                                  // R7
          if (m_cmd[0]) s = m_data[7];
          m_adr  = {m_adr[6:0], sda};
          m_data = {m_data[6:0], 1'b0};
          m_tick++;
          if (m_tick == 17) begin                       // R8
            m_data = tbl(m_adr); m_ack = 1; m_tick = 0;
          end
        end
      end
    end
    m_scl = scl; m_sda = s; ret = s;
  endtask

  task automatic check(input string tag, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: dev_sda=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // driver: one strobe, expected level pushed to the scoreboard
  task automatic put(input bit scl, input bit sda, input string tag);
    bit e;
    @(negedge clk);
    bus_wr = 1'b1; bus_scl = scl; bus_sda = sda;
    model_step(scl, sda, e);
    exp_v.push_back(e);
    exp_tag.push_back(tag);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send_bit(input bit b, input string tag);
    put(1'b0, b, tag); put(1'b1, b, tag); put(1'b0, b, tag);
  endtask

  task automatic send_byte(input bit [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(v[i], tag);
  endtask

  task automatic ack_slot(input string tag);
    put(1'b0, 1'b1, tag); put(1'b1, 1'b1, tag); put(1'b0, 1'b1, tag);
  endtask

  task automatic start_cond();
    put(1'b0, 1'b1, "R2"); put(1'b1, 1'b1, "R2"); put(1'b1, 1'b0, "R2"); put(1'b0, 1'b0, "R2");
  endtask

  task automatic stop_cond();
    put(1'b0, 1'b0, "R10"); put(1'b1, 1'b0, "R10"); put(1'b1, 1'b1, "R10");
  endtask

  // one full transfer: command, ack, address, ack
  task automatic transfer(input bit [7:0] cmd, input bit [7:0] adr, input string tag);
    start_cond();
    send_byte(cmd, "R5");
    ack_slot("R6");
    send_byte(adr, tag);
    ack_slot("R8");
  endtask

  // monitor: compare after each registered strobe
  always @(posedge clk) stb_seen <= bus_wr;

  always @(negedge clk) begin
    if (stb_seen && exp_v.size() > 0) begin
      bit    e;
      string t;
      e = exp_v.pop_front();
      t = exp_tag.pop_front();
      check(t, dev_sda, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset level", dev_sda, 1'b1);

    // R3: noise and a stop while idle, host bit echoed
    send_bit(1'b0, "R3");
    send_bit(1'b1, "R3");
    send_bit(1'b0, "R3");
    stop_cond();

    // write-type transfer selecting address 0x03 (read flag 0: host bits echoed)
    transfer(8'hA0, 8'h03, "R11");
    // R7/R9: read flag set, out comes byte at 0x03 = 0x0D
    transfer(8'hA1, 8'h3F, "R9");
    transfer(8'hA1, 8'h7F, "R9");   // out 0xD0
    transfer(8'hA1, 8'h80, "R9");   // out 0xF4
    transfer(8'hA1, 8'h00, "R9");   // out 0x00 (upper half)
    transfer(8'hA1, 8'h1B, "R7");   // out 0x80
    transfer(8'hA1, 8'h05, "R7");   // out 0x14

    // R4: skewed rising edge in mid-command takes no bit
    start_cond();
    send_bit(1'b1, "R4");
    put(1'b0, 1'b0, "R4"); put(1'b1, 1'b1, "R4"); put(1'b0, 1'b1, "R4");
    send_byte(8'h6B, "R4");
    ack_slot("R6");
    send_byte(8'h02, "R4");
    ack_slot("R8");

    // R6: acknowledge forced even on a skewed rise
    start_cond();
    send_byte(8'hA1, "R5");
    put(1'b0, 1'b0, "R6"); put(1'b1, 1'b1, "R6"); put(1'b0, 1'b1, "R6");
    send_byte(8'h06, "R7");
    ack_slot("R8");

    // R10: stop in mid-command keeps the count, then frame continues
    start_cond();
    send_bit(1'b1, "R10");
    send_bit(1'b0, "R10");
    stop_cond();
    send_byte(8'h35, "R10");
    ack_slot("R6");
    send_byte(8'h01, "R10");
    ack_slot("R8");

    // R2: restart in mid-address resynchronises
    start_cond();
    send_byte(8'hA1, "R5");
    ack_slot("R6");
    send_bit(1'b1, "R2");
    send_bit(1'b0, "R2");
    transfer(8'hA1, 8'h04, "R2");
    transfer(8'hA1, 8'h00, "R9");   // out byte at 0x04 = 0x0A

    repeat (4) @(negedge clk);
    if (exp_v.size() != 0) begin
      total++; bad++;
      $display("FAIL R11: %0d results missing, expected 0", exp_v.size());
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule